// File: doc/BRIEF.md
# Bit-Sliced Arithmetic and Logic Unit

This block is the combinational arithmetic and logic unit of a small 8-bit controller datapath. It takes two operands, a 3-bit operation code and the current carry flag. In the same cycle it returns a result byte, the next carry flag and a zero indication, all bound for the status register. It holds no state. The surrounding pipeline registers whatever it needs.

The datapath is a ripple chain of identical 2-bit slices. The carry passes from each slice to the next. The operand width is always twice the slice count, so a different data width means only a different value of the slice-count parameter.

When the operation is not arithmetic or logic, the A operand is forced to zero and the slices add it to B with no incoming carry. Operand B therefore reaches the result unchanged. This is the path used for moves and loads. Subtraction adds the inverted B operand with a carry-in, so a carry-out of one means that no borrow occurred.

Top module: `bslice_alu`

## Requirements
- R1: Operation code 3'b000 (plain add) gives {carry_out, result} = A + B, with the incoming carry ignored.
- R2: Operation code 3'b001 (add with carry) gives {carry_out, result} = A + B + carry_in.
- R3: Operation code 3'b010 (subtract) gives {carry_out, result} = A + ~B + 1. carry_out is 1 exactly when A >= B, meaning no borrow.
- R4: Operation code 3'b011 (subtract with borrow) gives {carry_out, result} = A + ~B + carry_in, where carry_in = 0 stands for a pending borrow.
- R5: Operation codes 3'b100, 3'b101 and 3'b110 give result = A AND B, A OR B and A XOR B, bit by bit.
- R6: Operation code 3'b111 (pass) gives result = B for any A and any carry_in.
- R7: For the three logic codes and the pass code, carry_out equals carry_in.
- R8: zero_out is 1 exactly when every bit of result is 0, for every operation code.
- R9: A carry produced in the lowest slice ripples through every slice boundary to carry_out. For example, add of 8'hFF and 8'h01 gives result 8'h00 with carry_out 1.
- R10: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 2*SLICES | Operand A, forced to zero internally for the pass code |
| op_b | input | 2*SLICES | Operand B |
| op_code | input | 3 | Operation select |
| carry_in | input | 1 | Current carry flag |
| result | output | 2*SLICES | Operation result |
| carry_out | output | 1 | Next carry flag |
| zero_out | output | 1 | High when result is all zeros |

## Verification
The carry chain and the zero detector both produce a flag from the same operation, so both can change at once.

The bench provokes this overlap in several ways:
- It adds 8'hFF and 8'h01, which wraps the result to zero and sets the carry.
- It subtracts equal operands, which gives zero with no borrow.
- It uses subtract-with-borrow on operands that differ by one.

For each case, both flags and the result are compared against values the bench computes with plain integer arithmetic on the same operands. A wide sweep across every operation code and both carry values then checks that no flag is ever taken from a stale or neighbouring result.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_ADC  = 3'b001,
    OP_SUB  = 3'b010,
    OP_SBB  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_PASS = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    FN_SUM = 2'd0,
    FN_AND = 2'd1,
    FN_OR  = 2'd2,
    FN_XOR = 2'd3
  } slice_fn_e;

  typedef enum logic [1:0] {
    CI_ZERO = 2'd0,
    CI_ONE  = 2'd1,
    CI_FLAG = 2'd2
  } cin_sel_e;

  localparam int SLICE_W = 2;

endpackage

// File: rtl/alu_opdec.sv
module alu_opdec
  import alu_pkg::*;
(
  input  logic [2:0] op_code,
  output slice_fn_e  fn,
  output logic       clr_a,
  output logic       inv_b,
  output cin_sel_e   cin_sel,
  output logic       keep_carry
);

  always_comb begin
    fn         = FN_SUM;
    clr_a      = 1'b0;
    inv_b      = 1'b0;
    cin_sel    = CI_ZERO;
    keep_carry = 1'b0;
    case (op_code)
      OP_ADD: begin
        cin_sel = CI_ZERO;
      end
      OP_ADC: begin
        cin_sel = CI_FLAG;
      end
      OP_SUB: begin
        inv_b   = 1'b1;
        cin_sel = CI_ONE;
      end
      OP_SBB: begin
        inv_b   = 1'b1;
        cin_sel = CI_FLAG;
      end
      OP_AND: begin
        fn         = FN_AND;
        keep_carry = 1'b1;
      end
      OP_OR: begin
        fn         = FN_OR;
        keep_carry = 1'b1;
      end
      OP_XOR: begin
        fn         = FN_XOR;
        keep_carry = 1'b1;
      end
      default: begin
        // pass: A cleared, B added to zero with no carry-in
        clr_a      = 1'b1;
        keep_carry = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_slice2.sv
module alu_slice2
  import alu_pkg::*;
(
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  input  slice_fn_e          fn,
  output logic [SLICE_W-1:0] y,
  output logic               cout,
  output logic               nz
);

  logic [SLICE_W:0]   c;
  logic [SLICE_W-1:0] sum;

  always_comb begin
    c[0] = cin;
    for (int i = 0; i < SLICE_W; i++) begin
      sum[i]   = a[i] ^ b[i] ^ c[i];
      c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end
  end

  always_comb begin
    case (fn)
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      default: y = sum;
    endcase
  end

  assign cout = c[SLICE_W];
  assign nz   = |y;

endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
  parameter int N = 4
) (
  input  logic [N-1:0] nz,
  output logic         zero
);

  assign zero = ~|nz;

endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
  import alu_pkg::*;
#(
  parameter int SLICES = 4,
  localparam int DW = SLICE_W * SLICES
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [2:0]    op_code,
  input  logic          carry_in,
  output logic [DW-1:0] result,
  output logic          carry_out,
  output logic          zero_out
);

  slice_fn_e      fn;
  logic           clr_a;
  logic           inv_b;
  cin_sel_e       cin_sel;
  logic           keep_carry;
  logic [DW-1:0]  a_eff;
  logic [DW-1:0]  b_eff;
  logic [SLICES:0] chain;
  logic [SLICES-1:0] slice_nz;

  alu_opdec u_dec (
    .op_code    (op_code),
    .fn         (fn),
    .clr_a      (clr_a),
    .inv_b      (inv_b),
    .cin_sel    (cin_sel),
    .keep_carry (keep_carry)
  );

  assign a_eff = clr_a ? '0 : op_a;
  assign b_eff = inv_b ? ~op_b : op_b;

  always_comb begin
    case (cin_sel)
      CI_ONE:  chain[0] = 1'b1;
      CI_FLAG: chain[0] = carry_in;
      default: chain[0] = 1'b0;
    endcase
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    alu_slice2 u_slice (
      .a    (a_eff[s*SLICE_W +: SLICE_W]),
      .b    (b_eff[s*SLICE_W +: SLICE_W]),
      .cin  (chain[s]),
      .fn   (fn),
      .y    (result[s*SLICE_W +: SLICE_W]),
      .cout (chain[s+1]),
      .nz   (slice_nz[s])
    );
  end

  alu_zero_det #(.N(SLICES)) u_zero (
    .nz   (slice_nz),
    .zero (zero_out)
  );

  assign carry_out = keep_carry ? carry_in : chain[SLICES];

endmodule

// File: rtl/bslice_alu_chk.sv
module bslice_alu_chk
  import alu_pkg::*;
#(
  parameter int SLICES = 4,
  localparam int DW = SLICE_W * SLICES
) (
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [2:0]    op_code,
  input logic          carry_in,
  input logic [DW-1:0] result,
  input logic          carry_out,
  input logic          zero_out
);

  logic [DW:0] add_ref;
  logic [DW:0] sub_ref;

  always_comb begin
    add_ref = {1'b0, op_a} + {1'b0, op_b}
              + {{DW{1'b0}}, (op_code == OP_ADC) & carry_in};
    sub_ref = {1'b0, op_a} + {1'b0, ~op_b}
              + {{DW{1'b0}}, (op_code == OP_SUB) | carry_in};
  end

  always_comb begin
    if (!$isunknown({op_a, op_b, op_code, carry_in})) begin
      // R1
      if (op_code == OP_ADD || op_code == OP_ADC)
        add_sum_chk: assert ({carry_out, result} == add_ref)
          else $error("add/adc mismatch");
      // R3
      if (op_code == OP_SUB || op_code == OP_SBB)
        sub_diff_chk: assert ({carry_out, result} == sub_ref)
          else $error("sub/sbb mismatch");
      // R6
      if (op_code == OP_PASS)
        pass_b_chk: assert (result == op_b)
          else $error("pass result differs from B");
      // R7
      if (op_code[2])
        carry_hold_chk: assert (carry_out == carry_in)
          else $error("carry not held");
      // R8
      zero_flag_chk: assert (zero_out == (result == '0))
        else $error("zero flag mismatch");
    end
  end

endmodule

bind bslice_alu bslice_alu_chk #(.SLICES(SLICES)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .op_code   (op_code),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out),
  .zero_out  (zero_out)
);

// File: tb/bslice_alu_bench.sv
module bslice_alu_bench;

  logic       clk;
  logic       rst_n;
  logic [7:0] op_a;
  logic [7:0] op_b;
  logic [2:0] op_code;
  logic       carry_in;
  logic [7:0] result;
  logic       carry_out;
  logic       zero_out;

  int checks;
  int fails;
  bit done;

  bslice_alu u_bslice_alu (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_code   (op_code),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .zero_out  (zero_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // independent model: returns {zero, carry, result}
  function automatic logic [9:0] model(input logic [2:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic ci);
    int s;
    logic [7:0] r;
    logic co;
    co = ci;
    case (op)
      3'd0: begin s = int'(a) + int'(b);               r = s[7:0]; co = s[8]; end
      3'd1: begin s = int'(a) + int'(b) + int'(ci);    r = s[7:0]; co = s[8]; end
      3'd2: begin s = int'(a) - int'(b);               r = s[7:0]; co = (a >= b); end
      3'd3: begin s = int'(a) - int'(b) - int'(!ci);   r = s[7:0]; co = (s >= 0); end
      3'd4: r = a & b;
      3'd5: r = a | b;
      3'd6: r = a ^ b;
      default: r = b;
    endcase
    return {(r == 8'h00), co, r};
  endfunction

  task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got z=%0b c=%0b r=%02h, expected z=%0b c=%0b r=%02h",
               tag, got[9], got[8], got[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ci);
    @(posedge clk);
    op_code  = op;
    op_a     = a;
    op_b     = b;
    carry_in = ci;
    @(negedge clk);
  endtask

  task automatic run(input string tag, input logic [2:0] op, input logic [7:0] a,
                     input logic [7:0] b, input logic ci);
    apply(op, a, b, ci);
    check(tag, {zero_out, carry_out, result}, model(op, a, b, ci));
  endtask

  task automatic t_reset;
    apply(3'd0, 8'h00, 8'h00, 1'b0);
    check("R8 reset-state", {zero_out, carry_out, result}, {1'b1, 1'b0, 8'h00});
  endtask

  task automatic t_add;
    run("R1 add", 3'd0, 8'h12, 8'h34, 1'b1);
    run("R1 add carry ignored", 3'd0, 8'h80, 8'h80, 1'b1);
    apply(3'd0, 8'hFF, 8'h01, 1'b0);
    check("R9 ripple", {zero_out, carry_out, result}, {1'b1, 1'b1, 8'h00});
    run("R9 ripple mid", 3'd0, 8'h0F, 8'h01, 1'b0);
  endtask

  task automatic t_adc;
    run("R2 adc ci=1", 3'd1, 8'hFE, 8'h01, 1'b1);
    run("R2 adc ci=0", 3'd1, 8'hFE, 8'h01, 1'b0);
  endtask

  task automatic t_sub;
    apply(3'd2, 8'h55, 8'h55, 1'b0);
    check("R3 sub equal", {zero_out, carry_out, result}, {1'b1, 1'b1, 8'h00});
    apply(3'd2, 8'h10, 8'h20, 1'b1);
    check("R3 sub borrow", {zero_out, carry_out, result}, {1'b0, 1'b0, 8'hF0});
  endtask

  task automatic t_sbb;
    apply(3'd3, 8'h21, 8'h20, 1'b0);
    check("R4 sbb to zero", {zero_out, carry_out, result}, {1'b1, 1'b1, 8'h00});
    run("R4 sbb no borrow in", 3'd3, 8'h21, 8'h20, 1'b1);
    run("R4 sbb underflow", 3'd3, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_logic;
    run("R5 and", 3'd4, 8'hF0, 8'h3C, 1'b1);
    run("R5 or", 3'd5, 8'hA0, 8'h05, 1'b0);
    run("R5 xor", 3'd6, 8'hFF, 8'h0F, 1'b1);
    apply(3'd4, 8'hF0, 8'h0F, 1'b1);
    check("R7 and zero keeps carry", {zero_out, carry_out, result}, {1'b1, 1'b1, 8'h00});
  endtask

  task automatic t_pass;
    apply(3'd7, 8'hFF, 8'h5A, 1'b1);
    check("R6 pass", {zero_out, carry_out, result}, {1'b0, 1'b1, 8'h5A});
    apply(3'd7, 8'h33, 8'h5A, 1'b0);
    check("R6 pass A ignored", {zero_out, carry_out, result}, {1'b0, 1'b0, 8'h5A});
    apply(3'd7, 8'hFF, 8'h00, 1'b1);
    check("R8 pass zero", {zero_out, carry_out, result}, {1'b1, 1'b1, 8'h00});
  endtask

  task automatic t_history;
    run("R10 first", 3'd1, 8'h7F, 8'h7F, 1'b1);
    run("R10 other", 3'd2, 8'h01, 8'hFE, 1'b0);
    run("R10 repeat", 3'd1, 8'h7F, 8'h7F, 1'b1);
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a += 17)
        for (int b = 0; b < 256; b += 15)
          for (int c = 0; c < 2; c++)
            run("R8 sweep", 3'(op), 8'(a), 8'(b), 1'(c));
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    op_a = '0; op_b = '0; op_code = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset;
    t_add;
    t_adc;
    t_sub;
    t_sbb;
    t_logic;
    t_pass;
    t_history;
    t_sweep;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule